// File: doc/BRIEF.md
# Per-Function Power Manager with Auto-Wake

This block governs power conservation for each on-card I/O function on its own. Each function has a small state machine, an idle counter, a wake-up timer and a clock-enable generator. Host accesses arrive as one select line per function. The block forwards each select to its function only when that function is awake. While a sleeping function wakes, the block holds the host in a wait state. Card-level software sees two controls per function. The first is an automatic idle power-down with a programmable timeout. The second is a clock control that can stop the function clock or divide it. A single card-wide power-down input overrides everything. While it is set, no function is powered. Host accesses made in that time finish at once, and reads return all ones.

Each function's machine has four states:

- `ST_ON`: the function is powered and clocked.
- `ST_SLEEP`: the function was powered down by the idle timeout, or after a forced power-down ended.
- `ST_WAKE`: the function is powered and its wake-up timer is running.
- `ST_FORCED`: the card-wide power-down bit is set.

The machine moves between them on these transitions:

- **idle_expire** (ST_ON to ST_SLEEP): automatic mode is on and the idle count reaches its limit.
- **access_wake** (ST_SLEEP to ST_WAKE): the host selects the function.
- **wake_done** (ST_WAKE to ST_ON): the wake timer has run out.
- **force_down** (any state to ST_FORCED): the card power-down bit is high.
- **force_release** (ST_FORCED to ST_SLEEP): the card power-down bit drops.

In `ST_ON`, any access restarts the idle count.

Top module: `fn_power_mgr`

## Requirements
- R1: After reset every function is in ST_ON: `fn_pwr_on` is all ones, `fn_sel` is zero and `host_wait` is low.
- R2: Each function's power state, idle count and clock enable depend only on its own configuration and select; activity on one function never changes another.
- R3: With `auto_en` set and a non-zero `idle_limit` L, a function powers down after L consecutive cycles with its select low. The first cycle of `fn_pwr_on` low is the L+1-th idle cycle. Every selected cycle restarts the count. With `auto_en` clear or L = 0, the function never powers down by itself.
- R4: A select to a function in ST_SLEEP raises `host_wait` in that same cycle. It keeps `host_wait` high for 1 + W cycles in total, where W is the function's `wake_cycles`. `fn_sel` rises in the cycle `host_wait` falls, and `host_wait` and `fn_sel` are never high together.
- R5: `fn_pwr_on` of a function is high exactly in ST_ON and ST_WAKE.
- R6: While a function's `clk_stop` is set, its `fn_clk_en` stays low whatever `clk_div` holds.
- R7: With `clk_stop` clear, `clk_div` codes 0, 1, 2, 3 make `fn_clk_en` pulse once every 1, 2, 4 and 8 cycles. Any 64-cycle window of a powered function carries 64, 32, 16 and 8 pulses. A powered-down function has `fn_clk_en` low.
- R8: When `card_pwrdn` is high, every function is in ST_FORCED from the next cycle on, with `fn_pwr_on` low. Selects are never forwarded and `host_wait` stays low, starting in the same cycle.
- R9: A select made while `card_pwrdn` is high completes at once. A read returns all ones on `host_rdata` and does not wake the function. After `card_pwrdn` falls, the function stays powered down until its next select.
- R10: While a selected function is in ST_ON, `host_rdata` carries that function's `fn_rdata` lane. Lane i is `fn_rdata[i*DW +: DW]`. `host_rdata` is zero when nothing is selected or the selected function is waking.
- R11: A `wake_cycles` value of 0 behaves as 1, so a wake-up always stalls the host for at least two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| card_pwrdn | input | 1 | Card-wide power-down bit from the card status register |
| auto_en | input | NFN | Per-function automatic idle power-down enable |
| idle_limit | input | NFN*IDLE_W | Per-function idle timeout in clock cycles (0 disables) |
| wake_cycles | input | NFN*WAKE_W | Per-function wake-up stall length in cycles |
| clk_stop | input | NFN | Per-function clock stop request |
| clk_div | input | NFN*DIV_W | Per-function clock divide code (0:/1, 1:/2, 2:/4, 3:/8) |
| host_sel | input | NFN | Per-function host access select, at most one high |
| fn_rdata | input | NFN*DW | Read data lanes from the functions |
| host_wait | output | 1 | Stall to the host while a function wakes |
| host_rdata | output | DW | Read data returned to the host |
| fn_sel | output | NFN | Select forwarded to each function |
| fn_pwr_on | output | NFN | Power enable for each function |
| fn_clk_en | output | NFN | Clock enable for each function |

## Verification
The host-facing outputs all follow the inputs of the same cycle: `fn_sel`, `host_wait` and `host_rdata`. State changes show one cycle after the edge that takes them. A wake-up therefore holds `host_wait` for the select cycle plus W cycles. An idle power-down first shows `fn_pwr_on` low in the cycle after the L-th idle one. The card power-down masks selects at once but drops power only from the next cycle. The bench drives inputs on the falling edge and samples every output 1 ns later. It compares them with a cycle model that advances its state only on the following rising edge, so each expected value falls in the cycle the requirement names. Directed sequences also count wait cycles and clock-enable pulses across whole windows.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [1:0] {
        ST_ON     = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_WAKE   = 2'd2,
        ST_FORCED = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/fpm_fn_fsm.sv
module fpm_fn_fsm
    import fpm_pkg::*;
#(
    parameter int IDLE_W = 16,
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_pwrdn,
    input  logic              auto_en,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic [WAKE_W-1:0] wake_cycles,
    input  logic              host_sel,
    output logic              fn_sel,
    output logic              wait_req,
    output logic              ones_req,
    output logic              pwr_on
);
    pwr_state_t        state, state_n;
    logic [IDLE_W-1:0] cnt, cnt_n;
    logic [IDLE_W-1:0] wake_last;
    logic              idle_hit;

    assign wake_last = (wake_cycles == '0) ? '0 : (IDLE_W'(wake_cycles) - IDLE_W'(1));
    assign idle_hit  = auto_en && (idle_limit != '0) && (cnt == idle_limit - IDLE_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ON;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (card_pwrdn) begin
            state_n = ST_FORCED;
            cnt_n   = '0;
        end else begin
            unique case (state)
                ST_ON: begin
                    if (host_sel) begin
                        cnt_n = '0;
                    end else if (idle_hit) begin
                        state_n = ST_SLEEP;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + IDLE_W'(1);
                    end
                end
                ST_SLEEP: begin
                    if (host_sel) begin
                        state_n = ST_WAKE;
                        cnt_n   = '0;
                    end
                end
                ST_WAKE: begin
                    if (cnt >= wake_last) begin
                        state_n = ST_ON;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + IDLE_W'(1);
                    end
                end
                ST_FORCED: begin
                    state_n = ST_SLEEP;
                    cnt_n   = '0;
                end
                default: begin
                    state_n = ST_FORCED;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        fn_sel   = 1'b0;
        wait_req = 1'b0;
        ones_req = host_sel && card_pwrdn;
        pwr_on   = 1'b0;
        unique case (state)
            ST_ON: begin
                pwr_on = 1'b1;
                fn_sel = host_sel && !card_pwrdn;
            end
            ST_WAKE: begin
                pwr_on   = 1'b1;
                wait_req = host_sel && !card_pwrdn;
            end
            ST_SLEEP, ST_FORCED: begin
                wait_req = host_sel && !card_pwrdn;
            end
            default: begin
                pwr_on = 1'b0;
            end
        endcase
    end

    // R8
    forced_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_pwrdn |=> (state == ST_FORCED && !pwr_on));

    // R3
    access_keeps_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && host_sel && !card_pwrdn) |=> (state == ST_ON));

    // R4
    sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && host_sel && !card_pwrdn) |=> (state == ST_WAKE && !fn_sel));

    // R9
    forced_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FORCED && !card_pwrdn) |=> (state == ST_SLEEP && !pwr_on));
endmodule

// File: rtl/fpm_clk_ctl.sv
module fpm_clk_ctl #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             clk_stop,
    input  logic [DIV_W-1:0] clk_div,
    output logic             clk_en
);
    localparam int CW = (1 << DIV_W) - 1;

    logic [CW-1:0] phase;
    logic [CW-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + CW'(1);
    end

    always_comb begin
        mask   = CW'((1 << clk_div) - 1);
        clk_en = pwr_on && !clk_stop && ((phase & mask) == '0);
    end

    // R7
    div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && clk_div != '0) |=> (!clk_en || clk_div != $past(clk_div)));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_stop && $past(clk_stop)) |-> !clk_en);
endmodule

// File: rtl/fpm_host_mux.sv
module fpm_host_mux #(
    parameter int NFN = 2,
    parameter int DW  = 8
) (
    input  logic [NFN-1:0]    fn_sel_v,
    input  logic [NFN-1:0]    wait_v,
    input  logic [NFN-1:0]    ones_v,
    input  logic [NFN*DW-1:0] fn_rdata,
    output logic              host_wait,
    output logic [DW-1:0]     host_rdata
);
    always_comb begin
        host_wait  = |wait_v;
        host_rdata = '0;
        for (int i = 0; i < NFN; i++) begin
            if (ones_v[i])
                host_rdata = '1;
            else if (fn_sel_v[i])
                host_rdata = fn_rdata[i*DW +: DW];
        end
    end
endmodule

// File: rtl/fn_power_mgr.sv
module fn_power_mgr #(
    parameter int NFN    = 2,
    parameter int DW     = 8,
    parameter int IDLE_W = 16,
    parameter int WAKE_W = 4,
    parameter int DIV_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  card_pwrdn,
    input  logic [NFN-1:0]        auto_en,
    input  logic [NFN*IDLE_W-1:0] idle_limit,
    input  logic [NFN*WAKE_W-1:0] wake_cycles,
    input  logic [NFN-1:0]        clk_stop,
    input  logic [NFN*DIV_W-1:0]  clk_div,
    input  logic [NFN-1:0]        host_sel,
    input  logic [NFN*DW-1:0]     fn_rdata,
    output logic                  host_wait,
    output logic [DW-1:0]         host_rdata,
    output logic [NFN-1:0]        fn_sel,
    output logic [NFN-1:0]        fn_pwr_on,
    output logic [NFN-1:0]        fn_clk_en
);
    logic [NFN-1:0] wait_v;
    logic [NFN-1:0] ones_v;

    for (genvar g = 0; g < NFN; g++) begin : g_fn
        fpm_fn_fsm #(
            .IDLE_W(IDLE_W),
            .WAKE_W(WAKE_W)
        ) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .card_pwrdn (card_pwrdn),
            .auto_en    (auto_en[g]),
            .idle_limit (idle_limit[g*IDLE_W +: IDLE_W]),
            .wake_cycles(wake_cycles[g*WAKE_W +: WAKE_W]),
            .host_sel   (host_sel[g]),
            .fn_sel     (fn_sel[g]),
            .wait_req   (wait_v[g]),
            .ones_req   (ones_v[g]),
            .pwr_on     (fn_pwr_on[g])
        );

        fpm_clk_ctl #(
            .DIV_W(DIV_W)
        ) u_clk (
            .clk     (clk),
            .rst_n   (rst_n),
            .pwr_on  (fn_pwr_on[g]),
            .clk_stop(clk_stop[g]),
            .clk_div (clk_div[g*DIV_W +: DIV_W]),
            .clk_en  (fn_clk_en[g])
        );
    end

    fpm_host_mux #(
        .NFN(NFN),
        .DW (DW)
    ) u_mux (
        .fn_sel_v  (fn_sel),
        .wait_v    (wait_v),
        .ones_v    (ones_v),
        .fn_rdata  (fn_rdata),
        .host_wait (host_wait),
        .host_rdata(host_rdata)
    );

    // R4
    wait_excl_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wait |-> (fn_sel == '0));

    // R9
    pwrdn_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_pwrdn && host_sel != '0) |-> (host_rdata == '1 && !host_wait));

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(host_sel));
endmodule

// File: tb/fn_power_mgr_test.sv
`timescale 1ns/1ps
module fn_power_mgr_test;
    localparam int NFN = 2, DW = 8, IW = 16, WW = 4, DV = 2;
    localparam int S_ON = 0, S_SLEEP = 1, S_WAKE = 2, S_FORCED = 3;

    logic clk = 0, rst_n = 0, card_pwrdn = 0;
    logic [NFN-1:0]    auto_en = 0, clk_stop = 0, host_sel = 0;
    logic [NFN*IW-1:0] idle_limit = 0;
    logic [NFN*WW-1:0] wake_cycles = 0;
    logic [NFN*DV-1:0] clk_div = 0;
    logic [NFN*DW-1:0] fn_rdata = 0;
    logic              host_wait;
    logic [DW-1:0]     host_rdata;
    logic [NFN-1:0]    fn_sel, fn_pwr_on, fn_clk_en;

    fn_power_mgr #(.NFN(NFN), .DW(DW), .IDLE_W(IW), .WAKE_W(WW), .DIV_W(DV)) uut (.*);

    always #5 clk = ~clk;

    int vectors = 0, miscompares = 0;
    int mst[NFN], mcnt[NFN], mdiv[NFN];
    logic [NFN-1:0] last_pwr, last_clken, last_sel;
    logic last_wait;
    logic [DW-1:0] last_rdata;
    string phase = "R1 reset";

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s [%s]: actual %0h expected %0h", tag, phase, got, exp);
        end
    endtask

    function automatic int wake_eff(int i);
        int w = int'(wake_cycles[i*WW +: WW]);
        return (w == 0) ? 1 : w;
    endfunction

    task automatic cyc();
        logic [NFN-1:0] e_sel, e_pwr, e_clk;
        logic e_wait, e_ones;
        logic [DW-1:0] e_rd;
        #1;
        e_sel = 0; e_pwr = 0; e_clk = 0; e_wait = 0; e_ones = 0; e_rd = 0;
        for (int i = 0; i < NFN; i++) begin
            int mask = (1 << int'(clk_div[i*DV +: DV])) - 1;
            e_pwr[i] = (mst[i] == S_ON) || (mst[i] == S_WAKE);
            e_sel[i] = host_sel[i] && !card_pwrdn && (mst[i] == S_ON);
            if (host_sel[i] && !card_pwrdn && mst[i] != S_ON) e_wait = 1;
            if (host_sel[i] && card_pwrdn) e_ones = 1;
            e_clk[i] = e_pwr[i] && !clk_stop[i] && ((mdiv[i] & mask) == 0);
            if (e_sel[i]) e_rd = fn_rdata[i*DW +: DW];
        end
        if (e_ones) e_rd = '1;
        chk(card_pwrdn ? "R8" : "R4", fn_sel, e_sel);
        chk("R4", host_wait, e_wait);
        chk("R5", fn_pwr_on, e_pwr);
        chk(clk_stop != 0 ? "R6" : "R7", fn_clk_en, e_clk);
        chk(card_pwrdn ? "R9" : "R10", host_rdata, e_rd);
        last_pwr = fn_pwr_on; last_clken = fn_clk_en; last_sel = fn_sel;
        last_wait = host_wait; last_rdata = host_rdata;
        @(posedge clk);
        for (int i = 0; i < NFN; i++) begin
            int lim = int'(idle_limit[i*IW +: IW]);
            mdiv[i] = (mdiv[i] + 1) % 8;
            if (card_pwrdn) begin
                mst[i] = S_FORCED; mcnt[i] = 0;
            end else begin
                case (mst[i])
                    S_ON: if (host_sel[i]) mcnt[i] = 0;
                          else if (auto_en[i] && lim != 0 && mcnt[i] == lim - 1) begin
                              mst[i] = S_SLEEP; mcnt[i] = 0;
                          end else mcnt[i] = (mcnt[i] + 1) % 65536;
                    S_SLEEP: if (host_sel[i]) begin mst[i] = S_WAKE; mcnt[i] = 0; end
                    S_WAKE: if (mcnt[i] >= wake_eff(i) - 1) begin mst[i] = S_ON; mcnt[i] = 0; end
                            else mcnt[i]++;
                    default: begin mst[i] = S_SLEEP; mcnt[i] = 0; end
                endcase
            end
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R4 watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        int n, cnt;
        void'($urandom(32'd4711));
        for (int i = 0; i < NFN; i++) begin mst[i] = S_ON; mcnt[i] = 0; mdiv[i] = 0; end
        fn_rdata = 16'hA55A;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        cyc();
        chk("R1", last_pwr, 2'b11);
        chk("R1", {last_wait, last_sel}, 3'b000);

        // R3 / R2: fn0 auto sleeps after 5 idle cycles, fn1 stays on
        phase = "R3 idle";
        auto_en = 2'b01; idle_limit = {16'd0, 16'd5}; wake_cycles = {4'd2, 4'd3};
        host_sel = 2'b01; cyc(); host_sel = 0;
        repeat (5) cyc();
        chk("R3", last_pwr[0], 1'b1);
        cyc();
        chk("R3", last_pwr[0], 1'b0);
        chk("R2", last_pwr[1], 1'b1);
        repeat (20) cyc();
        chk("R3", last_pwr[1], 1'b1);

        // R4: wake stall is 1 + W cycles
        phase = "R4 wake";
        host_sel = 2'b01; n = 0;
        for (int k = 0; k < 40; k++) begin cyc(); if (!last_wait) break; n++; end
        chk("R4", n, 4);
        chk("R4", last_sel, 2'b01);
        chk("R10", last_rdata, 8'h5A);
        host_sel = 0;

        // R11: wake 0 acts as 1
        phase = "R11 wake0";
        wake_cycles = {4'd2, 4'd0};
        repeat (8) cyc();
        host_sel = 2'b01; n = 0;
        for (int k = 0; k < 40; k++) begin cyc(); if (!last_wait) break; n++; end
        chk("R11", n, 2);
        host_sel = 0;

        // R8 / R9: card power-down forces, reads give ones, no wake
        phase = "R8 forced";
        card_pwrdn = 1; cyc();
        cyc();
        chk("R8", last_pwr, 2'b00);
        phase = "R9 read";
        host_sel = 2'b10; cyc();
        chk("R9", last_rdata, 8'hFF);
        chk("R9", last_wait, 1'b0);
        host_sel = 0; card_pwrdn = 0;
        repeat (4) cyc();
        chk("R9", last_pwr, 2'b00);
        host_sel = 2'b10;
        for (int k = 0; k < 40; k++) begin cyc(); if (!last_wait) break; end
        chk("R9", last_pwr[1], 1'b1);
        host_sel = 0;

        // R7 / R6: divider pulse counts, stop priority
        phase = "R7 div";
        auto_en = 0;
        host_sel = 2'b01;
        for (int k = 0; k < 40; k++) begin cyc(); if (!last_wait) break; end
        host_sel = 0;
        for (int d = 0; d < 4; d++) begin
            clk_div = {2'(d), 2'(3 - d)};
            cnt = 0; n = 0;
            for (int k = 0; k < 64; k++) begin cyc(); cnt += last_clken[0]; n += last_clken[1]; end
            chk("R7", cnt, 64 >> (3 - d));
            chk("R7", n, 64 >> d);
        end
        phase = "R6 stop";
        clk_stop = 2'b10; clk_div = {2'd1, 2'd0};
        cnt = 0; n = 0;
        for (int k = 0; k < 32; k++) begin cyc(); cnt += last_clken[0]; n += last_clken[1]; end
        chk("R6", n, 0);
        chk("R2", cnt, 32);
        clk_stop = 0;

        // random mix against the cycle model
        phase = "random";
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 3) == 0) begin
                int r = $urandom_range(0, 2);
                host_sel = (r == 0) ? 2'b00 : ((r == 1) ? 2'b01 : 2'b10);
            end
            if ($urandom_range(0, 29) == 0) card_pwrdn = ~card_pwrdn;
            if ($urandom_range(0, 99) == 0) begin
                auto_en = 2'($urandom_range(0, 3));
                clk_stop = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
                clk_div = 4'($urandom_range(0, 15));
                wake_cycles = {4'($urandom_range(0, 5)), 4'($urandom_range(0, 5))};
                idle_limit = {16'($urandom_range(0, 12)), 16'($urandom_range(0, 12))};
            end
            fn_rdata = 16'($urandom);
            cyc();
        end
        summary();
        $finish;
    end
endmodule